// File: doc/BRIEF.md
# Buffered Dual-Compare PWM Output Channel

This block is one output channel of a modular timer. It watches a time-base count that is shared between channels and generates a pulse-width-modulated pin from two compare values. A leading compare turns the pulse on and a trailing compare turns it off. Each transition is taken when the matching count value is left, not when it is reached. When the leading value is zero, the transition is taken when the count arrives at it instead.

Software writes the leading value into a shadow register. That value reaches the comparator only at a period boundary, so the waveform never shows a half-updated period. The trailing value is written directly. An idle-polarity input selects the level of the pin outside the pulse. An output-disable input parks the pin at that level. A sticky flag marks every period boundary and is cleared by writing one.

Top module: `pwmc_channel`

## Requirements
- R1: After reset the pin equals `idle_pol` and `flag` is 0. The active leading value, the shadow value and the trailing value are all zero.
- R2: With a non-zero active leading value, a leading event occurs in the first prescaled cycle (`presc_en`=1) whose count differs from the leading value, provided the previous prescaled cycle matched it. The pin takes the non-idle level (`~idle_pol`) right after the clock edge that ends that cycle.
- R3: A trailing event occurs in the same way when the count stops matching the trailing value. The pin returns to `idle_pol` right after that edge.
- R4: When the active leading value is zero, the leading event occurs instead in the first prescaled cycle whose count equals zero after a prescaled cycle that did not.
- R5: When a leading event and a trailing event fall in the same cycle, the pin goes to `idle_pol`. A leading value of zero with a trailing match on the last count of the period therefore gives 0% duty.
- R6: Cycles with `presc_en`=0 neither sample the count nor produce events.
- R7: While `out_dis` is 1, the pin is driven to `idle_pol` from the clock edge after `out_dis` is first seen. Events in those cycles do not move it.
- R8: After `out_dis` falls, the pin keeps the idle level until the next leading or trailing event. After that, normal operation resumes.
- R9: `flag` becomes 1 on every trailing event, whatever the state of `out_dis`. A `flag_clr` pulse clears it one edge later. A trailing event in the same cycle wins over the clear.
- R10: A write on `lead_wr_en` changes only the shadow value. The active leading value takes the shadow value on the next trailing event.
- R11: The pin level is the internal pulse state XOR `idle_pol`, so `idle_pol`=1 inverts the whole waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_bus | input | CNT_W | Shared time-base count |
| presc_en | input | 1 | Prescaled sample enable |
| lead_wr_en | input | 1 | Write strobe for the shadow leading value |
| lead_wr_data | input | CNT_W | Shadow leading value to write |
| trail_wr_en | input | 1 | Write strobe for the trailing value |
| trail_wr_data | input | CNT_W | Trailing value to write |
| idle_pol | input | 1 | Pin level outside the pulse |
| out_dis | input | 1 | Forces the pin to the idle level |
| flag_clr | input | 1 | Write-one-to-clear for the flag |
| pwm_out | output | 1 | PWM pin |
| flag | output | 1 | Sticky period-boundary flag |

## Verification
The in-line properties check, on every cycle, these rules:
- the disable parks the pulse state one edge later;
- coincident events resolve to idle;
- a trailing event sets the flag;
- a clear without a trailing event drops the flag;
- the pulse state is held when there is no event;
- the active leading value moves only at a load and equals the shadow afterwards.

Only the bench's scenarios can show the exact cycle in which the pin moves relative to the count. The same holds for the zero-leading rising-edge rule, the 0% duty waveform and the one-period lag of a shadow write. Gating by the prescaler enable and the inversion under `idle_pol` are also shown only by the scenarios.

// File: rtl/pwmc_pkg.sv
package pwmc_pkg;

   // Smallest and largest supported time-base widths
   localparam int unsigned MIN_CNT_W = 2;
   localparam int unsigned MAX_CNT_W = 32;

   // Which edge of a registered compare hit produces an event
   typedef enum logic [0:0] {
      EDGE_FALL = 1'b0,
      EDGE_RISE = 1'b1
   } edge_sel_e;

   // Edge pair from one compare unit
   typedef struct packed {
      logic rise;
      logic fall;
   } hit_edges_t;

endpackage

// File: rtl/pwmc_match_det.sv
module pwmc_match_det
   import pwmc_pkg::*;
#(
   parameter int unsigned CNT_W     = 24,
   parameter bit          ZERO_RISE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             presc_en,
   input  logic [CNT_W-1:0] cnt_bus,
   input  logic [CNT_W-1:0] cmp_val,
   output logic             ev
);

   localparam logic [CNT_W-1:0] ZERO_VAL = '0;

   logic       hit_now;
   logic       hit_q;
   hit_edges_t edges;
   edge_sel_e  sel;

   assign hit_now = (cnt_bus == cmp_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_q <= 1'b0;
      end else if (presc_en) begin
         hit_q <= hit_now;
      end
   end

   always_comb begin
      edges.rise = presc_en &  hit_now & ~hit_q;
      edges.fall = presc_en & ~hit_now &  hit_q;
   end

   generate
      if (ZERO_RISE) begin : g_zero_rise
         assign sel = (cmp_val == ZERO_VAL) ? EDGE_RISE : EDGE_FALL;
      end else begin : g_fall_only
         assign sel = EDGE_FALL;
      end
   endgenerate

   assign ev = (sel == EDGE_RISE) ? edges.rise : edges.fall;

   // R6: the sampled hit only moves in prescaled cycles
   a_r6_hold_unsampled: assert property (@(posedge clk) disable iff (!rst_n)
      !presc_en |=> $stable(hit_q));

endmodule

// File: rtl/pwmc_cmp_regs.sv
module pwmc_cmp_regs #(
   parameter int unsigned CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lead_wr_en,
   input  logic [CNT_W-1:0] lead_wr_data,
   input  logic             trail_wr_en,
   input  logic [CNT_W-1:0] trail_wr_data,
   input  logic             load,
   output logic [CNT_W-1:0] lead_act,
   output logic [CNT_W-1:0] trail_act
);

   logic [CNT_W-1:0] shadow_q;
   logic [CNT_W-1:0] shadow_nxt;
   logic [CNT_W-1:0] lead_q;
   logic [CNT_W-1:0] trail_q;

   assign shadow_nxt = lead_wr_en ? lead_wr_data : shadow_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q <= '0;
         lead_q   <= '0;
         trail_q  <= '0;
      end else begin
         shadow_q <= shadow_nxt;
         if (load) begin
            lead_q <= shadow_nxt;
         end
         if (trail_wr_en) begin
            trail_q <= trail_wr_data;
         end
      end
   end

   assign lead_act  = lead_q;
   assign trail_act = trail_q;

   // R10: the active leading value moves only at a period boundary
   a_r10_hold_between_loads: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(lead_q));

   // R10: after a load the active value equals the shadow
   a_r10_load_copies_shadow: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (lead_q == shadow_q));

endmodule

// File: rtl/pwmc_out_stage.sv
module pwmc_out_stage (
   input  logic clk,
   input  logic rst_n,
   input  logic ev_lead,
   input  logic ev_trail,
   input  logic out_dis,
   input  logic flag_clr,
   input  logic idle_pol,
   output logic pwm_out,
   output logic flag
);

   logic active_q;
   logic flag_q;

   // The pulse state: 0 means the pin is at its idle level
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
      end else if (out_dis) begin
         active_q <= 1'b0;
      end else if (ev_trail) begin
         active_q <= 1'b0;
      end else if (ev_lead) begin
         active_q <= 1'b1;
      end
   end

   // The flag ignores the disable input
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (ev_trail) begin
         flag_q <= 1'b1;
      end else if (flag_clr) begin
         flag_q <= 1'b0;
      end
   end

   assign pwm_out = active_q ^ idle_pol;
   assign flag    = flag_q;

   // R7: disable parks the pulse state one edge later
   a_r7_dis_parks: assert property (@(posedge clk) disable iff (!rst_n)
      out_dis |=> !active_q);

   // R5: coincident leading and trailing events resolve to idle
   a_r5_coincide_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_lead && ev_trail) |=> !active_q);

   // R8: no event and no disable leaves the pulse state alone
   a_r8_hold_no_event: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_dis && !ev_lead && !ev_trail) |=> $stable(active_q));

   // R9: a trailing event raises the flag
   a_r9_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
      ev_trail |=> flag_q);

   // R9: a clear without a trailing event drops the flag
   a_r9_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && !ev_trail) |=> !flag_q);

endmodule

// File: rtl/pwmc_channel.sv
module pwmc_channel
   import pwmc_pkg::*;
#(
   parameter int unsigned CNT_W          = 24,
   parameter bit          LEAD_ZERO_RISE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt_bus,
   input  logic             presc_en,
   input  logic             lead_wr_en,
   input  logic [CNT_W-1:0] lead_wr_data,
   input  logic             trail_wr_en,
   input  logic [CNT_W-1:0] trail_wr_data,
   input  logic             idle_pol,
   input  logic             out_dis,
   input  logic             flag_clr,
   output logic             pwm_out,
   output logic             flag
);

   generate
      if (CNT_W < MIN_CNT_W || CNT_W > MAX_CNT_W) begin : g_bad_width
         $error("pwmc_channel: CNT_W out of supported range");
      end
   endgenerate

   logic [CNT_W-1:0] lead_act;
   logic [CNT_W-1:0] trail_act;
   logic             ev_lead;
   logic             ev_trail;

   pwmc_cmp_regs #(.CNT_W(CNT_W)) i_regs (
      .clk           (clk),
      .rst_n         (rst_n),
      .lead_wr_en    (lead_wr_en),
      .lead_wr_data  (lead_wr_data),
      .trail_wr_en   (trail_wr_en),
      .trail_wr_data (trail_wr_data),
      .load          (ev_trail),
      .lead_act      (lead_act),
      .trail_act     (trail_act)
   );

   pwmc_match_det #(.CNT_W(CNT_W), .ZERO_RISE(LEAD_ZERO_RISE)) i_lead_det (
      .clk      (clk),
      .rst_n    (rst_n),
      .presc_en (presc_en),
      .cnt_bus  (cnt_bus),
      .cmp_val  (lead_act),
      .ev       (ev_lead)
   );

   pwmc_match_det #(.CNT_W(CNT_W), .ZERO_RISE(1'b0)) i_trail_det (
      .clk      (clk),
      .rst_n    (rst_n),
      .presc_en (presc_en),
      .cnt_bus  (cnt_bus),
      .cmp_val  (trail_act),
      .ev       (ev_trail)
   );

   pwmc_out_stage i_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev_lead  (ev_lead),
      .ev_trail (ev_trail),
      .out_dis  (out_dis),
      .flag_clr (flag_clr),
      .idle_pol (idle_pol),
      .pwm_out  (pwm_out),
      .flag     (flag)
   );

endmodule

// File: tb/test_pwmc_channel.sv
`timescale 1ns/1ps
module test_pwmc_channel;

   localparam int CW = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [CW-1:0] cnt_bus = '0;
   logic          presc_en = 1'b0;
   logic          lead_wr_en = 1'b0;
   logic [CW-1:0] lead_wr_data = '0;
   logic          trail_wr_en = 1'b0;
   logic [CW-1:0] trail_wr_data = '0;
   logic          idle_pol = 1'b0;
   logic          out_dis = 1'b0;
   logic          flag_clr = 1'b0;
   logic          pwm_out;
   logic          flag;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   pwmc_channel #(.CNT_W(CW)) i_pwmc_channel (
      .clk(clk), .rst_n(rst_n), .cnt_bus(cnt_bus), .presc_en(presc_en),
      .lead_wr_en(lead_wr_en), .lead_wr_data(lead_wr_data),
      .trail_wr_en(trail_wr_en), .trail_wr_data(trail_wr_data),
      .idle_pol(idle_pol), .out_dis(out_dis), .flag_clr(flag_clr),
      .pwm_out(pwm_out), .flag(flag)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   // Drive one count value, let one edge pass, sample 2 ns later
   task automatic step(input int c, input bit en);
      cnt_bus  = CW'(c);
      presc_en = en;
      @(posedge clk);
      #2;
   endtask

   task automatic wr_regs(input bit lw, input int ld, input bit tw, input int td);
      lead_wr_en    = lw;
      lead_wr_data  = CW'(ld);
      trail_wr_en   = tw;
      trail_wr_data = CW'(td);
      presc_en      = 1'b0;
      @(posedge clk);
      #2;
      lead_wr_en  = 1'b0;
      trail_wr_en = 1'b0;
   endtask

   // One period of counts 0..9; bit c of act_mask is the expected pulse state after count c
   task automatic run_period(input string req, input logic [9:0] act_mask,
                             input logic [9:0] dis_mask, input int clr_at);
      for (int c = 0; c < 10; c++) begin
         out_dis  = dis_mask[c];
         flag_clr = (c == clr_at);
         step(c, 1'b1);
         chk(req, pwm_out, act_mask[c] ^ idle_pol);
      end
      out_dis  = 1'b0;
      flag_clr = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 pin at reset", pwm_out, idle_pol);
      chk("R1 flag at reset", flag, 1'b0);
   endtask

   task automatic t_first_period();
      // Active leading value is still 0 (R1), shadow gets 3 (R10)
      wr_regs(1'b1, 3, 1'b1, 7);
      run_period("R4 zero leading uses rising match", 10'h0FF, 10'h000, 99);
      chk("R9 flag set by trailing event", flag, 1'b1);
   endtask

   task automatic t_steady();
      run_period("R2/R3 steady lead=3 trail=7", 10'h0F0, 10'h000, 2);
      chk("R9 flag set again after clear", flag, 1'b1);
      // Clear with no trailing event in the same cycle
      flag_clr = 1'b1;
      step(0, 1'b0);
      flag_clr = 1'b0;
      chk("R9 flag cleared", flag, 1'b0);
      // Clear in the same cycle as a trailing event: the set wins
      run_period("R2 lead edge timing", 10'h0F0, 10'h000, 8);
      chk("R9 set wins over clear", flag, 1'b1);
   endtask

   task automatic t_prescale();
      for (int c = 0; c < 3; c++) step(c, 1'b1);
      step(3, 1'b1);
      chk("R6 no change on match entry", pwm_out, idle_pol);
      step(4, 1'b0);
      chk("R6 disabled cycle gives no event", pwm_out, idle_pol);
      step(4, 1'b1);
      chk("R6 event once enabled", pwm_out, ~idle_pol);
      for (int c = 5; c < 10; c++) step(c, 1'b1);
      chk("R3 trailing after prescale test", pwm_out, idle_pol);
   endtask

   task automatic t_shadow();
      for (int c = 0; c < 3; c++) step(c, 1'b1);
      // Shadow write mid-period does not affect this period
      wr_regs(1'b1, 5, 1'b0, 0);
      for (int c = 3; c < 10; c++) begin
         step(c, 1'b1);
         chk("R10 old leading value still active", pwm_out, (c >= 4 && c <= 7) ^ idle_pol);
      end
      run_period("R10 new leading value after boundary", 10'h0C0, 10'h000, 99);
   endtask

   task automatic t_disable();
      // Disable while the pulse is high, held through the trailing event
      run_period("R7 disable one clock later", 10'h040, 10'h180, 2);
      chk("R9 flag set while disabled", flag, 1'b1);
      // Disable across the leading event, released before the trailing one
      run_period("R7/R8 disable ignores event and holds", 10'h000, 10'h060, 99);
      run_period("R8 normal after next event", 10'h0C0, 10'h000, 99);
   endtask

   task automatic t_polarity();
      idle_pol = 1'b1;
      #1;
      chk("R11 idle level follows polarity", pwm_out, 1'b1);
      run_period("R11 inverted waveform", 10'h0C0, 10'h000, 99);
      idle_pol = 1'b0;
      #1;
   endtask

   task automatic t_zero_duty();
      wr_regs(1'b1, 0, 1'b1, 9);
      run_period("R2/R3 lead=5 trail=9", 10'h3C0, 10'h000, 99);
      // Boundary at count 0 loads leading value 0
      run_period("R10 load of zero leading value", 10'h000, 10'h000, 99);
      run_period("R5 coincident events give 0% duty", 10'h000, 10'h000, 0);
      chk("R5 flag still set at boundary", flag, 1'b1);
      run_period("R5 0% duty repeats", 10'h000, 10'h000, 99);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2;
      t_reset();
      rst_n = 1'b1;
      @(posedge clk);
      #2;
      t_reset();
      t_first_period();
      t_steady();
      t_prescale();
      t_shadow();
      t_disable();
      t_polarity();
      t_zero_duty();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule